// File: doc/BRIEF.md
# Two-Cluster Power Request Register Block

This block is the register face of a power controller that serves two processor clusters, a big one and a little one. Software asks for a new performance level on one cluster by writing an index to that cluster's level register. It can also issue a configuration read command that fetches one packed operating-point word from a small internal table. A sequencer accepts one request at a time. It holds the request for a fixed, parameterised number of cycles, which stands in for the real multi-millisecond operation. It then posts either a completion flag or an error flag in a shared status register. A level interrupt stays asserted while any flag is set, and a read of the status register clears all flags.

The same register space also holds several other controls. There is a wake-up interrupt mask with a masked view of the raw wake sources, and a power-down enable for each cluster. Each CPU has a resume-address mailbox, and a read-only word reports which CPUs are idling in wait-for-interrupt. Access goes through a simple single-cycle read/write port whose read data is registered. Voltage regulators, clock generators and the bus fabric are outside the block.

Top module: `pwr_req_regs`

## Requirements
- R1: After reset, the status word is 0, `req_irq` is 0, both cluster level registers read 0, the wake mask reads 0 and both power-down enables are 0.
- R2: A write to the big-cluster level register (0x00) starts a big-cluster request (type 0). Exactly REQ_CYCLES clock edges after the write edge, status bit 0 becomes 1. The level register keeps its old value until that edge and then reads the written index.
- R3: A write to the little-cluster level register (0x08) starts a little-cluster request (type 1). It completes the same way, setting status bit 4, and 0x08 then reads the new index.
- R4: A level index at or above NUM_OPPS ends its request with the error flag (bit 1 for big, bit 5 for little) and no completion flag, and the level register stays unchanged.
- R5: A write to 0x10 with bit 31 set, function code 6 in bits 23:20 and a word offset in bits 19:0 starts a config read (type 2). Offsets 0x304+i address big entry i and offsets 0x30C+i address little entry i. On completion, status bit 8 is set and 0x74 returns the word {millivolts[11:0], frequency[19:0]}. Big entry i holds 900+25i mV and 25000+5000i. Little entry i holds 850+25i mV and 17500+2500i.
- R6: A config command with another function code, an offset outside both tables, or an entry index at or above NUM_OPPS ends with error bit 9 and leaves 0x74 unchanged. A write to 0x10 with bit 31 clear starts nothing.
- R7: A request written while another is in progress is rejected: its own error flag is set on the write edge. The running request completes normally with its own result.
- R8: `req_irq` is 1 exactly while any status flag is set. A read of the status register (0x18) returns the flags and clears them all.
- R9: Bit 0 of 0x04 (big) and of 0x0C (little) reads 1 while that cluster's level request is in progress.
- R10: In the wake mask (0x24), bits 0..BIG_CPUS-1 and 4..4+LIT_CPUS-1 are writable, as are bits 11:10; all other bits read 0. 0x28 returns `wake_raw`, 0x2C returns `wake_raw` ANDed with the mask, and `wake_irq` is the OR of the masked bits.
- R11: 0x3C reads big CPU n in bit n and little CPU n in bit 3+n, taken from `wfi_big` and `wfi_lit`.
- R12: The resume mailboxes at 0x68+4n (big) and 0x78+4n (little) read back what was written. Bit 0 of 0x30 and of 0x34 holds the big and the little power-down enable, and these drive `pwrdn_en[0]` and `pwrdn_en[1]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid from the edge that samples the read |
| req_irq | output | 1 | Request status interrupt, level |
| wake_raw | input | 12 | Raw wake-up sources |
| wake_irq | output | 1 | OR of masked wake-up sources |
| wfi_big | input | BIG_CPUS | Big-cluster CPUs in wait-for-interrupt |
| wfi_lit | input | LIT_CPUS | Little-cluster CPUs in wait-for-interrupt |
| pwrdn_en | output | 2 | Power-down enables, bit 0 big, bit 1 little |

## Verification
The bench checks the interrupt on the edge just before completion and on the completion edge itself. A sequencer with a counter off by one would raise it a cycle early or late. It reads the level register while a request is still running, so a design that updated the level at the write would be caught. Every error route is covered: a level equal to the table size, an offset one entry past the last valid one, an offset outside both tables, and a wrong function code. A command with bit 31 clear is also sent, which a design that ignored the start bit would execute. Finally, a request written during a running config read must flag only its own error. A design that aborted or overwrote the running request would lose the completion flag or return the wrong word.

// File: rtl/pwr_req_pkg.sv
// Package: shared register offsets, request kinds and config constants
// for the two-cluster power request block.
// Assumes a 12-bit byte address space and 32-bit data words.
package pwr_req_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int WAKE_W = 12;

    typedef enum logic [1:0] {
        KIND_BIG = 2'd0,
        KIND_LIT = 2'd1,
        KIND_CFG = 2'd2
    } req_kind_e;

    localparam int NUM_KINDS = 3;

    localparam logic [ADDR_W-1:0] A_LVL_BIG  = 12'h000;
    localparam logic [ADDR_W-1:0] A_PEND_BIG = 12'h004;
    localparam logic [ADDR_W-1:0] A_LVL_LIT  = 12'h008;
    localparam logic [ADDR_W-1:0] A_PEND_LIT = 12'h00C;
    localparam logic [ADDR_W-1:0] A_CFG_CMD  = 12'h010;
    localparam logic [ADDR_W-1:0] A_STATUS   = 12'h018;
    localparam logic [ADDR_W-1:0] A_WMASK    = 12'h024;
    localparam logic [ADDR_W-1:0] A_WRAW     = 12'h028;
    localparam logic [ADDR_W-1:0] A_WSTAT    = 12'h02C;
    localparam logic [ADDR_W-1:0] A_PD_BIG   = 12'h030;
    localparam logic [ADDR_W-1:0] A_PD_LIT   = 12'h034;
    localparam logic [ADDR_W-1:0] A_STANDBY  = 12'h03C;
    localparam logic [ADDR_W-1:0] A_MBX_BIG  = 12'h068;
    localparam logic [ADDR_W-1:0] A_CFG_DATA = 12'h074;
    localparam logic [ADDR_W-1:0] A_MBX_LIT  = 12'h078;

    localparam int               CFG_GO_BIT   = 31;
    localparam logic [3:0]       CFG_FUNC_OPP = 4'd6;
    localparam logic [19:0]      OPP_BIG_WORD = 20'h304;
    localparam logic [19:0]      OPP_LIT_WORD = 20'h30C;

endpackage

// File: rtl/pwr_opp_table.sv
// Module: computed operating-point table.
// Returns the packed {millivolts, frequency} word for entry idx of the
// selected cluster. Entries follow a linear rule, so no storage is used.
// Assumes the results fit their 12-bit and 20-bit fields.
module pwr_opp_table #(
    parameter int          LVL_W     = 3,
    parameter logic [11:0] MV_BIG0   = 12'd900,
    parameter logic [11:0] MV_LIT0   = 12'd850,
    parameter logic [11:0] MV_STEP   = 12'd25,
    parameter logic [19:0] FR_BIG0   = 20'd25000,
    parameter logic [19:0] FR_BIG_ST = 20'd5000,
    parameter logic [19:0] FR_LIT0   = 20'd17500,
    parameter logic [19:0] FR_LIT_ST = 20'd2500
) (
    input  logic             lit_sel,
    input  logic [LVL_W-1:0] idx,
    output logic [31:0]      opp_word
);

    logic [11:0] mv;
    logic [19:0] fr;

    // Linear voltage and frequency for the selected entry.
    always_comb begin
        mv = (lit_sel ? MV_LIT0 : MV_BIG0) + 12'(idx) * MV_STEP;
        fr = lit_sel ? (FR_LIT0 + 20'(idx) * FR_LIT_ST)
                     : (FR_BIG0 + 20'(idx) * FR_BIG_ST);
        opp_word = {mv, fr};
    end

endmodule

// File: rtl/pwr_req_seq.sv
// Module: request sequencer.
// Accepts one request at a time, validates it on acceptance, holds it for
// REQ_CYCLES edges and then pulses completion or error for its kind.
// A start while busy produces an immediate error pulse for the new kind
// and leaves the held request alone. At most one start bit is high.
module pwr_req_seq
    import pwr_req_pkg::*;
#(
    parameter int REQ_CYCLES = 8,
    parameter int NUM_OPPS   = 5,
    parameter int LVL_W      = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_KINDS-1:0] start_i,
    input  logic [31:0]          wdata_i,
    output logic                 busy_o,
    output req_kind_e            kind_o,
    output logic [NUM_KINDS-1:0] set_cmp_o,
    output logic [NUM_KINDS-1:0] set_err_o,
    output logic [1:0]           lvl_upd_o,
    output logic [LVL_W-1:0]     lvl_val_o,
    output logic                 cfg_upd_o,
    output logic [31:0]          cfg_word_o
);

    localparam int CNT_W = $clog2(REQ_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(REQ_CYCLES - 1);

    logic             busy_q;
    req_kind_e        kind_q;
    logic [CNT_W-1:0] cnt_q;
    logic             ok_q;
    logic             lit_q;
    logic [LVL_W-1:0] idx_q;

    logic             accept;
    logic             done;
    req_kind_e        new_kind;
    logic             new_ok;
    logic             new_lit;
    logic [LVL_W-1:0] new_idx;
    logic [19:0]      woff, big_rel, lit_rel;
    logic             in_big, in_lit, func_ok;

    assign accept = (|start_i) && !busy_q;
    assign done   = busy_q && (cnt_q == '0);

    assign woff    = wdata_i[19:0];
    assign big_rel = woff - OPP_BIG_WORD;
    assign lit_rel = woff - OPP_LIT_WORD;
    assign in_big  = (woff >= OPP_BIG_WORD) && (big_rel < 20'(NUM_OPPS));
    assign in_lit  = (woff >= OPP_LIT_WORD) && (lit_rel < 20'(NUM_OPPS));
    assign func_ok = (wdata_i[23:20] == CFG_FUNC_OPP);

    // Decode and validate the request presented on this cycle.
    always_comb begin
        new_kind = KIND_BIG;
        new_lit  = 1'b0;
        new_ok   = 1'b0;
        new_idx  = wdata_i[LVL_W-1:0];
        if (start_i[KIND_CFG]) begin
            new_kind = KIND_CFG;
            new_lit  = !in_big;
            new_ok   = func_ok && (in_big || in_lit);
            new_idx  = in_big ? big_rel[LVL_W-1:0] : lit_rel[LVL_W-1:0];
        end else if (start_i[KIND_LIT]) begin
            new_kind = KIND_LIT;
            new_lit  = 1'b1;
            new_ok   = wdata_i < 32'(NUM_OPPS);
        end else begin
            new_ok   = wdata_i < 32'(NUM_OPPS);
        end
    end

    // Hold the accepted request and count down its latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            kind_q <= KIND_BIG;
            cnt_q  <= '0;
            ok_q   <= 1'b0;
            lit_q  <= 1'b0;
            idx_q  <= '0;
        end else if (accept) begin
            busy_q <= 1'b1;
            kind_q <= new_kind;
            cnt_q  <= CNT_LOAD;
            ok_q   <= new_ok;
            lit_q  <= new_lit;
            idx_q  <= new_idx;
        end else if (done) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q - 1'b1;
        end
    end

    // Per-kind completion and error events.
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_evt
        logic mine;
        assign mine         = done && (kind_q == req_kind_e'(2'(k)));
        assign set_cmp_o[k] = mine && ok_q;
        assign set_err_o[k] = (mine && !ok_q) || (start_i[k] && busy_q);
    end

    pwr_opp_table #(.LVL_W(LVL_W)) u_table (
        .lit_sel  (lit_q),
        .idx      (idx_q),
        .opp_word (cfg_word_o)
    );

    assign lvl_upd_o[0] = set_cmp_o[KIND_BIG];
    assign lvl_upd_o[1] = set_cmp_o[KIND_LIT];
    assign cfg_upd_o    = set_cmp_o[KIND_CFG];
    assign lvl_val_o    = idx_q;
    assign busy_o       = busy_q;
    assign kind_o       = kind_q;

    // R2: the countdown never exceeds the programmed latency.
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= CNT_LOAD));

    // R2: only one request can complete on any edge.
    a_r2_one_completion: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(set_cmp_o));

    // R7: a start while busy does not disturb the running request.
    a_r7_reject_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && (|start_i) && (cnt_q != '0))
        |=> (busy_q && $stable(kind_q) && $stable(idx_q) && $stable(ok_q)));

endmodule

// File: rtl/pwr_req_status.sv
// Module: request status flags and interrupt.
// Keeps a completion and an error flag per request kind, laid out as one
// nibble per kind (bit 4k complete, bit 4k+1 error). A read strobe clears
// all flags; a flag set on the same edge survives the clear.
module pwr_req_status
    import pwr_req_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_KINDS-1:0] set_cmp_i,
    input  logic [NUM_KINDS-1:0] set_err_i,
    input  logic                 rd_clr_i,
    output logic [31:0]          status_o,
    output logic                 irq_o
);

    logic [NUM_KINDS-1:0] cmp_q, err_q;

    // Sticky flags, cleared as a group by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
            err_q <= '0;
        end else begin
            cmp_q <= (rd_clr_i ? '0 : cmp_q) | set_cmp_i;
            err_q <= (rd_clr_i ? '0 : err_q) | set_err_i;
        end
    end

    // Place each kind's flags in its own nibble.
    always_comb begin
        status_o = '0;
        for (int k = 0; k < NUM_KINDS; k++) begin
            status_o[4*k]     = cmp_q[k];
            status_o[4*k + 1] = err_q[k];
        end
    end

    assign irq_o = |{cmp_q, err_q};

    // R8: a read with nothing new arriving leaves no flag behind.
    a_r8_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && !(|set_cmp_i) && !(|set_err_i)) |=> (status_o == 32'd0));

    // R8: without a read, flags are never lost.
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_i |=> ((status_o & $past(status_o)) == $past(status_o)));

endmodule

// File: rtl/pwr_req_regs.sv
// Module: top of the two-cluster power request block.
// Decodes the simple bus port, holds levels, wake mask, power-down enables
// and resume mailboxes, and registers read data on the sampling edge.
// Assumes BIG_CPUS <= 2 and LIT_CPUS <= 3 so mailboxes do not overlap the
// config data register, and NUM_OPPS <= 2**LVL_W.
module pwr_req_regs
    import pwr_req_pkg::*;
#(
    parameter int REQ_CYCLES = 8,
    parameter int NUM_OPPS   = 5,
    parameter int BIG_CPUS   = 2,
    parameter int LIT_CPUS   = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_en,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 req_irq,
    input  logic [WAKE_W-1:0]    wake_raw,
    output logic                 wake_irq,
    input  logic [BIG_CPUS-1:0]  wfi_big,
    input  logic [LIT_CPUS-1:0]  wfi_lit,
    output logic [1:0]           pwrdn_en
);

    localparam int LVL_W = 3;
    localparam logic [WAKE_W-1:0] WAKE_WR =
        12'hC00 | (((12'd1 << LIT_CPUS) - 12'd1) << 4) | ((12'd1 << BIG_CPUS) - 12'd1);

    logic                 wr, rd;
    logic [NUM_KINDS-1:0] start;
    logic                 busy;
    req_kind_e            kind;
    logic [NUM_KINDS-1:0] set_cmp, set_err;
    logic [1:0]           lvl_upd;
    logic [LVL_W-1:0]     lvl_val;
    logic                 cfg_upd;
    logic [31:0]          cfg_word;
    logic [31:0]          status;

    logic [LVL_W-1:0]     lvl_big_q, lvl_lit_q;
    logic [WAKE_W-1:0]    wmask_q;
    logic [1:0]           pd_q;
    logic [31:0]          cfg_data_q;
    logic [31:0]          mbx_big_q [BIG_CPUS];
    logic [31:0]          mbx_lit_q [LIT_CPUS];
    logic [31:0]          rd_mux;
    logic [31:0]          rdata_q;

    assign wr = bus_en && bus_we;
    assign rd = bus_en && !bus_we;

    assign start[KIND_BIG] = wr && (bus_addr == A_LVL_BIG);
    assign start[KIND_LIT] = wr && (bus_addr == A_LVL_LIT);
    assign start[KIND_CFG] = wr && (bus_addr == A_CFG_CMD) && bus_wdata[CFG_GO_BIT];

    pwr_req_seq #(
        .REQ_CYCLES (REQ_CYCLES),
        .NUM_OPPS   (NUM_OPPS),
        .LVL_W      (LVL_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .wdata_i    (bus_wdata),
        .busy_o     (busy),
        .kind_o     (kind),
        .set_cmp_o  (set_cmp),
        .set_err_o  (set_err),
        .lvl_upd_o  (lvl_upd),
        .lvl_val_o  (lvl_val),
        .cfg_upd_o  (cfg_upd),
        .cfg_word_o (cfg_word)
    );

    pwr_req_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_cmp_i (set_cmp),
        .set_err_i (set_err),
        .rd_clr_i  (rd && (bus_addr == A_STATUS)),
        .status_o  (status),
        .irq_o     (req_irq)
    );

    // Current levels change only when their request completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_big_q <= '0;
            lvl_lit_q <= '0;
        end else begin
            if (lvl_upd[0]) lvl_big_q <= lvl_val;
            if (lvl_upd[1]) lvl_lit_q <= lvl_val;
        end
    end

    // Config result register, loaded by a successful config read.
    always_ff @(posedge clk) begin
        if (!rst_n)       cfg_data_q <= '0;
        else if (cfg_upd) cfg_data_q <= cfg_word;
    end

    // Wake mask and power-down enables, plain software registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wmask_q <= '0;
            pd_q    <= '0;
        end else if (wr) begin
            if (bus_addr == A_WMASK)  wmask_q <= bus_wdata[WAKE_W-1:0] & WAKE_WR;
            if (bus_addr == A_PD_BIG) pd_q[0] <= bus_wdata[0];
            if (bus_addr == A_PD_LIT) pd_q[1] <= bus_wdata[0];
        end
    end

    for (genvar n = 0; n < BIG_CPUS; n++) begin : g_mbx_big
        // Resume-address mailbox for one big-cluster CPU.
        always_ff @(posedge clk) begin
            if (!rst_n) mbx_big_q[n] <= '0;
            else if (wr && (bus_addr == A_MBX_BIG + ADDR_W'(4*n))) mbx_big_q[n] <= bus_wdata;
        end
    end

    for (genvar n = 0; n < LIT_CPUS; n++) begin : g_mbx_lit
        // Resume-address mailbox for one little-cluster CPU.
        always_ff @(posedge clk) begin
            if (!rst_n) mbx_lit_q[n] <= '0;
            else if (wr && (bus_addr == A_MBX_LIT + ADDR_W'(4*n))) mbx_lit_q[n] <= bus_wdata;
        end
    end

    // Read multiplexer over every readable register.
    always_comb begin
        rd_mux = '0;
        case (bus_addr)
            A_LVL_BIG:  rd_mux = 32'(lvl_big_q);
            A_LVL_LIT:  rd_mux = 32'(lvl_lit_q);
            A_PEND_BIG: rd_mux = {31'd0, busy && (kind == KIND_BIG)};
            A_PEND_LIT: rd_mux = {31'd0, busy && (kind == KIND_LIT)};
            A_STATUS:   rd_mux = status;
            A_WMASK:    rd_mux = 32'(wmask_q);
            A_WRAW:     rd_mux = 32'(wake_raw);
            A_WSTAT:    rd_mux = 32'(wake_raw & wmask_q);
            A_PD_BIG:   rd_mux = {31'd0, pd_q[0]};
            A_PD_LIT:   rd_mux = {31'd0, pd_q[1]};
            A_CFG_DATA: rd_mux = cfg_data_q;
            A_STANDBY: begin
                for (int n = 0; n < BIG_CPUS; n++) rd_mux[n]     = wfi_big[n];
                for (int n = 0; n < LIT_CPUS; n++) rd_mux[3 + n] = wfi_lit[n];
            end
            default: begin
                for (int n = 0; n < BIG_CPUS; n++)
                    if (bus_addr == A_MBX_BIG + ADDR_W'(4*n)) rd_mux = mbx_big_q[n];
                for (int n = 0; n < LIT_CPUS; n++)
                    if (bus_addr == A_MBX_LIT + ADDR_W'(4*n)) rd_mux = mbx_lit_q[n];
            end
        endcase
    end

    // Registered read data, updated on the edge that samples a read.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata_q <= '0;
        else if (rd) rdata_q <= rd_mux;
    end

    assign bus_rdata = rdata_q;
    assign wake_irq  = |(wake_raw & wmask_q);
    assign pwrdn_en  = pd_q;

    // R4: a stored level is always a valid table index.
    a_r4_level_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(lvl_big_q) < 32'(NUM_OPPS)) && (32'(lvl_lit_q) < 32'(NUM_OPPS)));

    // R2: levels move only on a completion event.
    a_r2_level_moves_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        !(|lvl_upd) |=> ($stable(lvl_big_q) && $stable(lvl_lit_q)));

endmodule

// File: tb/pwr_req_regs_bench.sv
// Directed bench for pwr_req_regs: one task per scenario, each checking
// its own results. Inputs change on falling edges, outputs sampled there.
module pwr_req_regs_bench;

    localparam int LAT  = 8;
    localparam int NOPP = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        req_irq, wake_irq;
    logic [11:0] wake_raw = '0;
    logic [1:0]  wfi_big = '0;
    logic [2:0]  wfi_lit = '0;
    logic [1:0]  pwrdn_en;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    pwr_req_regs #(.REQ_CYCLES(LAT), .NUM_OPPS(NOPP), .BIG_CPUS(2), .LIT_CPUS(3)) u_pwr_req_regs (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .req_irq(req_irq), .wake_raw(wake_raw), .wake_irq(wake_irq),
        .wfi_big(wfi_big), .wfi_lit(wfi_lit), .pwrdn_en(pwrdn_en)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_en = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] opp(input bit lit, input int i);
        int mv, fr;
        mv = lit ? 850 + 25*i : 900 + 25*i;
        fr = lit ? 17500 + 2500*i : 25000 + 5000*i;
        return {mv[11:0], fr[19:0]};
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq", 32'(req_irq), 0);
        check("R1 pwrdn", 32'(pwrdn_en), 0);
        rd(12'h018, d); check("R1 status", d, 0);
        rd(12'h000, d); check("R1 big level", d, 0);
        rd(12'h008, d); check("R1 little level", d, 0);
        rd(12'h024, d); check("R1 wake mask", d, 0);
    endtask

    task automatic t_big_dvfs();
        logic [31:0] d;
        wr(12'h000, 32'd3);                    // write edge E0
        rd(12'h000, d); check("R2 level before done", d, 0);   // E1
        rd(12'h004, d); check("R9 big pending", d, 1);          // E2
        idle(LAT - 3);                         // after E(LAT-1)
        check("R2 irq one edge before done", 32'(req_irq), 0);
        idle(1);                               // after E(LAT)
        check("R8 irq on completion edge", 32'(req_irq), 1);
        rd(12'h004, d); check("R9 big not pending", d, 0);
        rd(12'h000, d); check("R2 level after done", d, 3);
        rd(12'h018, d); check("R2 status complete bit", d, 32'h1);
        check("R8 irq dropped by read", 32'(req_irq), 0);
        rd(12'h018, d); check("R8 status cleared", d, 0);
    endtask

    task automatic t_little_dvfs();
        logic [31:0] d;
        wr(12'h008, 32'd4);
        rd(12'h00C, d); check("R9 little pending", d, 1);
        rd(12'h004, d); check("R9 big idle during little", d, 0);
        idle(LAT);
        rd(12'h008, d); check("R3 little level", d, 4);
        rd(12'h018, d); check("R3 status bit 4", d, 32'h10);
    endtask

    task automatic t_bad_level();
        logic [31:0] d;
        wr(12'h000, 32'(NOPP));
        idle(LAT + 1);
        rd(12'h018, d); check("R4 big error bit", d, 32'h2);
        rd(12'h000, d); check("R4 big level kept", d, 3);
        wr(12'h008, 32'h100);
        idle(LAT + 1);
        rd(12'h018, d); check("R4 little error bit", d, 32'h20);
        rd(12'h008, d); check("R4 little level kept", d, 4);
    endtask

    task automatic t_cfg_read();
        logic [31:0] d;
        wr(12'h010, 32'h8060_0000 | 32'h306);
        idle(LAT + 1);
        rd(12'h018, d); check("R5 cfg complete bit 8", d, 32'h100);
        rd(12'h074, d); check("R5 big entry 2", d, opp(0, 2));
        wr(12'h010, 32'h8060_0000 | 32'h310);
        idle(LAT + 1);
        rd(12'h018, d); check("R5 cfg complete again", d, 32'h100);
        rd(12'h074, d); check("R5 little entry 4", d, opp(1, 4));
        wr(12'h010, 32'h8060_0000 | 32'h304);
        idle(LAT + 1);
        rd(12'h018, d); check("R5 cfg complete big 0", d, 32'h100);
        rd(12'h074, d); check("R5 big entry 0", d, opp(0, 0));
    endtask

    task automatic t_cfg_errors();
        logic [31:0] d;
        wr(12'h010, 32'h8050_0000 | 32'h305);
        idle(LAT + 1);
        rd(12'h018, d); check("R6 bad function", d, 32'h200);
        wr(12'h010, 32'h8060_0000 | 32'(12'h304 + NOPP));
        idle(LAT + 1);
        rd(12'h018, d); check("R6 entry past valid", d, 32'h200);
        wr(12'h010, 32'h8060_0000 | 32'h100);
        idle(LAT + 1);
        rd(12'h018, d); check("R6 offset outside tables", d, 32'h200);
        rd(12'h074, d); check("R6 data unchanged", d, opp(0, 0));
        wr(12'h010, 32'h0060_0306);
        idle(LAT + 1);
        check("R6 no start bit irq", 32'(req_irq), 0);
        rd(12'h018, d); check("R6 no start bit status", d, 0);
        rd(12'h074, d); check("R6 no start bit data", d, opp(0, 0));
    endtask

    task automatic t_reject();
        logic [31:0] d;
        wr(12'h010, 32'h8060_0000 | 32'h30D);  // little entry 1
        wr(12'h000, 32'd1);                    // rejected while busy
        check("R7 reject flags at once", 32'(req_irq), 1);
        idle(LAT);
        rd(12'h018, d); check("R7 status reject plus cfg done", d, 32'h102);
        rd(12'h074, d); check("R7 running result intact", d, opp(1, 1));
        rd(12'h000, d); check("R7 big level untouched", d, 3);
    endtask

    task automatic t_wake();
        logic [31:0] d;
        wr(12'h024, 32'hFFFF_FFFF);
        rd(12'h024, d); check("R10 writable mask bits", d, 32'hC73);
        wake_raw = 12'h004;
        idle(1);
        check("R10 unmasked source no irq", 32'(wake_irq), 0);
        rd(12'h028, d); check("R10 raw view", d, 32'h004);
        rd(12'h02C, d); check("R10 masked view empty", d, 0);
        wake_raw = 12'h401;
        idle(1);
        check("R10 wake irq", 32'(wake_irq), 1);
        rd(12'h02C, d); check("R10 masked view", d, 32'h401);
    endtask

    task automatic t_standby();
        logic [31:0] d;
        wfi_big = 2'b10; wfi_lit = 3'b101;
        rd(12'h03C, d); check("R11 standby layout", d, 32'h2A);
    endtask

    task automatic t_mbox();
        logic [31:0] d;
        wr(12'h06C, 32'hDEAD_0001);
        wr(12'h080, 32'h1234_5678);
        wr(12'h068, 32'h0000_0A00);
        rd(12'h06C, d); check("R12 big mailbox 1", d, 32'hDEAD_0001);
        rd(12'h068, d); check("R12 big mailbox 0", d, 32'h0000_0A00);
        rd(12'h080, d); check("R12 little mailbox 2", d, 32'h1234_5678);
        wr(12'h030, 32'd1);
        check("R12 pwrdn output", 32'(pwrdn_en), 32'h1);
        rd(12'h034, d); check("R12 little pwrdn reg", d, 0);
        wr(12'h034, 32'd1);
        wr(12'h030, 32'd0);
        check("R12 pwrdn swapped", 32'(pwrdn_en), 32'h2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_big_dvfs();
        t_little_dvfs();
        t_bad_level();
        t_cfg_read();
        t_cfg_errors();
        t_reject();
        t_wake();
        t_standby();
        t_mbox();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule